// File: doc/BRIEF.md
# Population Sort and Generation Sequencer

This block sequences the generations of a hardware evolutionary path planner. After the initial-population unit reports that the population memory is filled, the block reads every record and sorts the records by fitness. It then writes them back, so that the best record sits at address 0. Each generation it raises a request toward the random address unit and the crossover stage, collects a fixed number of evaluated offspring, and writes them into the population. The top few sorted records are protected from this write. The population is then sorted again and the generation count advances.

When the configured number of generations is complete, the block presents the record at the top of the sorted population as the planned path, with a one-cycle valid strobe. It then returns to idle and waits for the next initial population. The record fitness field is the most significant FIT_W bits of each record, and a smaller value means a better path.

Top module: `ea_sort_term_ctrl`

## Requirements
- R1: A synchronous reset puts the block in idle with mem_we, upd_req, xo_go and res_valid low, and clears the generation count, so that every run performs the full MAX_GEN generations.
- R2: No population memory write and no generation request occurs before init_done has been seen high.
- R3: Each sort leaves the population in memory at addresses 0..POP_SIZE-1 in ascending order of the fitness key, which is record bits [REC_W-1 -: FIT_W]. Records with equal keys keep their previous relative order.
- R4: Each generation starts with upd_req and xo_go high together for exactly one cycle, and only once the sorted population is in memory.
- R5: After a request, exactly N_OFFS records are taken, one on each cycle in which off_valid is high. With base = (sum over k of upd_addr[k*ADDR_W +: ADDR_W]) mod (POP_SIZE-ELITE), sampled with the first offspring, offspring number k is written to address ELITE + ((base + k) mod (POP_SIZE-ELITE)).
- R6: Addresses 0..ELITE-1 are never overwritten by offspring.
- R7: After the offspring are written, the population is sorted again and the generation count increments. While the count is below MAX_GEN, a new request follows.
- R8: After MAX_GEN generations, res_valid is high for exactly one cycle and res_path equals the record at address 0 of the final sorted population. A run issues exactly MAX_GEN requests.
- R9: off_valid outside the offspring-collection phase is ignored.
- R10: After the result, the block waits for a new init_done and then runs a complete new optimisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_done | input | 1 | Initial population has been written to memory |
| mem_addr | output | ADDR_W | Population memory address |
| mem_we | output | 1 | Population memory write enable |
| mem_wdata | output | REC_W | Population memory write data |
| mem_rdata | input | REC_W | Population memory read data, one cycle after the address |
| upd_req | output | 1 | Request for new random update addresses |
| upd_addr | input | N_UPD*ADDR_W | Random update addresses, field k at bits k*ADDR_W |
| xo_go | output | 1 | Crossover continue strobe |
| off_valid | input | 1 | Evaluated offspring present |
| off_data | input | REC_W | Evaluated offspring record |
| res_valid | output | 1 | Final result strobe |
| res_path | output | REC_W | Best path record, zero when res_valid is low |

## Verification
The bench builds the block with an 8-record population of 16-bit records and a 4-bit fitness key. It uses 2 protected records, 4 offspring per generation, 2 update-address fields and 3 generations. These sizes let a behavioural model in the bench hold and compare the whole population after every sort and every offspring merge. They also let the wrap-around of the replacement slots past the last address occur within a few generations. Two back-to-back runs cover repeated fitness values, which test the stability of the sort, as well as stray offspring strobes before initialisation and the restart after a result.

// File: rtl/ea_stc_pkg.sv
package ea_stc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_INIT,
    ST_SORT,
    ST_REQ_OFFSPRING,
    ST_WAIT_EVAL,
    ST_MERGE,
    ST_CHECK,
    ST_DONE
  } stc_state_e;

  typedef enum logic [1:0] {
    PH_LOAD,
    PH_PASS,
    PH_STORE
  } sort_phase_e;

  // folds the summed update addresses into the replaceable span
  function automatic int unsigned fold_base(input int unsigned sum,
                                            input int unsigned span);
    return sum % span;
  endfunction

  // address of offspring k, walking the inferior span with wrap-around
  function automatic int unsigned slot_of(input int unsigned base,
                                          input int unsigned k,
                                          input int unsigned elite,
                                          input int unsigned span);
    return elite + ((base + k) % span);
  endfunction

endpackage

// File: rtl/ea_stc_popbuf.sv
module ea_stc_popbuf #(
  parameter int POP    = 32,
  parameter int REC_W  = 144,
  parameter int FIT_W  = 7,
  parameter int ELITE  = 2,
  parameter int ADDR_W = $clog2(POP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_idx,
  input  logic [REC_W-1:0]  cap_data,
  input  logic              pass_en,
  input  logic              pass_odd,
  input  logic              pass_last,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_idx,
  input  logic [REC_W-1:0]  ins_data,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [REC_W-1:0]  rd_data,
  output logic [REC_W-1:0]  top_rec
);

  logic [REC_W-1:0] ent [POP];
  logic [REC_W-1:0] nxt [POP];
  logic [POP:0]     sw;
  logic             sorted_ok;

  assign sw[0]   = 1'b0;
  assign sw[POP] = 1'b0;

  // one comparator per adjacent pair; strict compare keeps ties in place
  for (genvar j = 0; j < POP - 1; j++) begin : g_pair
    localparam bit ODD = (j % 2) == 1;
    assign sw[j+1] = (pass_odd == ODD) &&
                     (ent[j][REC_W-1 -: FIT_W] > ent[j+1][REC_W-1 -: FIT_W]);
  end

  always_comb begin
    for (int i = 0; i < POP; i++) begin
      nxt[i] = ent[i];
      if (sw[i+1])   nxt[i] = ent[(i < POP - 1) ? i + 1 : i];
      else if (sw[i]) nxt[i] = ent[(i > 0) ? i - 1 : i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < POP; i++) begin
      if (cap_en && cap_idx == ADDR_W'(i))      ent[i] <= cap_data;
      else if (ins_en && ins_idx == ADDR_W'(i)) ent[i] <= ins_data;
      else if (pass_en)                         ent[i] <= nxt[i];
    end
  end

  assign rd_data = ent[rd_idx];
  assign top_rec = ent[0];

  always_comb begin
    sorted_ok = 1'b1;
    for (int j = 0; j < POP - 1; j++)
      if (ent[j][REC_W-1 -: FIT_W] > ent[j+1][REC_W-1 -: FIT_W]) sorted_ok = 1'b0;
  end

  AST_SORTED_AFTER_PASSES: assert property (@(posedge clk) disable iff (rst)
    pass_last |=> sorted_ok);  // R3
  AST_INSERT_INFERIOR: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> (ins_idx >= ADDR_W'(ELITE)));  // R6
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cap_en, pass_en, ins_en}));  // R5

endmodule

// File: rtl/ea_stc_seq.sv
module ea_stc_seq
  import ea_stc_pkg::*;
#(
  parameter int POP     = 32,
  parameter int ELITE   = 2,
  parameter int N_OFFS  = 22,
  parameter int N_UPD   = 8,
  parameter int MAX_GEN = 60,
  parameter int ADDR_W  = $clog2(POP)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    init_done,
  input  logic                    off_valid,
  input  logic [N_UPD*ADDR_W-1:0] upd_addr,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_we,
  output logic                    cap_en,
  output logic [ADDR_W-1:0]       cap_idx,
  output logic                    pass_en,
  output logic                    pass_odd,
  output logic                    pass_last,
  output logic                    ins_en,
  output logic [ADDR_W-1:0]       ins_idx,
  output logic                    upd_req,
  output logic                    xo_go,
  output logic                    res_valid
);

  localparam int SPAN  = POP - ELITE;
  localparam int CNT_W = $clog2(POP + 1);
  localparam int GEN_W = $clog2(MAX_GEN + 1);

  stc_state_e        state_q;
  sort_phase_e       ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GEN_W-1:0]  gen_q;
  logic [ADDR_W-1:0] base_q;
  logic              ldv_q;
  logic [ADDR_W-1:0] ldi_q;

  logic [ADDR_W-1:0] base_now;
  logic [ADDR_W-1:0] base_use;
  logic [ADDR_W-1:0] merge_addr;
  logic              load_issue;

  always_comb begin
    int unsigned acc;
    acc = 0;
    for (int k = 0; k < N_UPD; k++)
      acc = acc + 32'(upd_addr[k*ADDR_W +: ADDR_W]);
    base_now = ADDR_W'(fold_base(acc, SPAN));
  end

  assign base_use   = (cnt_q == '0) ? base_now : base_q;
  assign ins_idx    = ADDR_W'(slot_of(32'(base_use), 32'(cnt_q), ELITE, SPAN));
  assign merge_addr = ADDR_W'(slot_of(32'(base_q), 32'(cnt_q), ELITE, SPAN));
  assign load_issue = (state_q == ST_SORT) && (ph_q == PH_LOAD) && (cnt_q < CNT_W'(POP));

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = '0;
    if (state_q == ST_SORT && ph_q == PH_STORE) begin
      mem_we   = 1'b1;
      mem_addr = ADDR_W'(cnt_q);
    end else if (state_q == ST_MERGE) begin
      mem_we   = 1'b1;
      mem_addr = merge_addr;
    end else if (load_issue) begin
      mem_addr = ADDR_W'(cnt_q);
    end
  end

  assign cap_en    = ldv_q;
  assign cap_idx   = ldi_q;
  assign pass_en   = (state_q == ST_SORT) && (ph_q == PH_PASS);
  assign pass_odd  = cnt_q[0];
  assign pass_last = pass_en && (cnt_q == CNT_W'(POP - 1));
  assign ins_en    = (state_q == ST_WAIT_EVAL) && off_valid;
  assign upd_req   = (state_q == ST_REQ_OFFSPRING);
  assign xo_go     = (state_q == ST_REQ_OFFSPRING);
  assign res_valid = (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ph_q    <= PH_LOAD;
      cnt_q   <= '0;
      gen_q   <= '0;
      base_q  <= '0;
      ldv_q   <= 1'b0;
      ldi_q   <= '0;
    end else begin
      ldv_q <= load_issue;
      ldi_q <= ADDR_W'(cnt_q);
      case (state_q)
        ST_IDLE: begin
          gen_q   <= '0;
          cnt_q   <= '0;
          state_q <= ST_WAIT_INIT;
        end
        ST_WAIT_INIT: begin
          if (init_done) begin
            state_q <= ST_SORT;
            ph_q    <= PH_LOAD;
            cnt_q   <= '0;
          end
        end
        ST_SORT: begin
          case (ph_q)
            PH_LOAD: begin
              if (cnt_q == CNT_W'(POP)) begin
                ph_q  <= PH_PASS;
                cnt_q <= '0;
              end else cnt_q <= cnt_q + 1'b1;
            end
            PH_PASS: begin
              if (cnt_q == CNT_W'(POP - 1)) begin
                ph_q  <= PH_STORE;
                cnt_q <= '0;
              end else cnt_q <= cnt_q + 1'b1;
            end
            PH_STORE: begin
              if (cnt_q == CNT_W'(POP - 1)) begin
                state_q <= ST_CHECK;
                cnt_q   <= '0;
              end else cnt_q <= cnt_q + 1'b1;
            end
            default: ph_q <= PH_LOAD;
          endcase
        end
        ST_CHECK: begin
          state_q <= (gen_q == GEN_W'(MAX_GEN)) ? ST_DONE : ST_REQ_OFFSPRING;
        end
        ST_REQ_OFFSPRING: begin
          state_q <= ST_WAIT_EVAL;
          cnt_q   <= '0;
        end
        ST_WAIT_EVAL: begin
          if (off_valid) begin
            if (cnt_q == '0) base_q <= base_now;
            if (cnt_q == CNT_W'(N_OFFS - 1)) begin
              state_q <= ST_MERGE;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_MERGE: begin
          if (cnt_q == CNT_W'(N_OFFS - 1)) begin
            gen_q   <= gen_q + 1'b1;
            state_q <= ST_SORT;
            ph_q    <= PH_PASS;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    upd_req |=> !upd_req);  // R4
  AST_QUIET_BEFORE_INIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_INIT) |-> (!mem_we && !xo_go));  // R2
  AST_ELITE_SAFE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MERGE) |-> (mem_addr >= ADDR_W'(ELITE)));  // R6
  AST_GEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    gen_q <= GEN_W'(MAX_GEN));  // R7
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);  // R8
  AST_RES_AFTER_ALL: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (gen_q == GEN_W'(MAX_GEN)));  // R8

endmodule

// File: rtl/ea_sort_term_ctrl.sv
module ea_sort_term_ctrl #(
  parameter int POP_SIZE = 32,
  parameter int REC_W    = 144,
  parameter int FIT_W    = 7,
  parameter int ELITE    = 2,
  parameter int N_OFFS   = 22,
  parameter int N_UPD    = 8,
  parameter int MAX_GEN  = 60,
  localparam int ADDR_W  = $clog2(POP_SIZE)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    init_done,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_we,
  output logic [REC_W-1:0]        mem_wdata,
  input  logic [REC_W-1:0]        mem_rdata,
  output logic                    upd_req,
  input  logic [N_UPD*ADDR_W-1:0] upd_addr,
  output logic                    xo_go,
  input  logic                    off_valid,
  input  logic [REC_W-1:0]        off_data,
  output logic                    res_valid,
  output logic [REC_W-1:0]        res_path
);

  logic              cap_en;
  logic [ADDR_W-1:0] cap_idx;
  logic              pass_en;
  logic              pass_odd;
  logic              pass_last;
  logic              ins_en;
  logic [ADDR_W-1:0] ins_idx;
  logic [REC_W-1:0]  top_rec;

  ea_stc_seq #(
    .POP(POP_SIZE), .ELITE(ELITE), .N_OFFS(N_OFFS),
    .N_UPD(N_UPD), .MAX_GEN(MAX_GEN), .ADDR_W(ADDR_W)
  ) seq_i (
    .clk(clk), .rst(rst), .init_done(init_done), .off_valid(off_valid),
    .upd_addr(upd_addr), .mem_addr(mem_addr), .mem_we(mem_we),
    .cap_en(cap_en), .cap_idx(cap_idx), .pass_en(pass_en),
    .pass_odd(pass_odd), .pass_last(pass_last), .ins_en(ins_en),
    .ins_idx(ins_idx), .upd_req(upd_req), .xo_go(xo_go),
    .res_valid(res_valid)
  );

  ea_stc_popbuf #(
    .POP(POP_SIZE), .REC_W(REC_W), .FIT_W(FIT_W),
    .ELITE(ELITE), .ADDR_W(ADDR_W)
  ) buf_i (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(mem_rdata), .pass_en(pass_en), .pass_odd(pass_odd),
    .pass_last(pass_last), .ins_en(ins_en), .ins_idx(ins_idx),
    .ins_data(off_data), .rd_idx(mem_addr), .rd_data(mem_wdata),
    .top_rec(top_rec)
  );

  assign res_path = res_valid ? top_rec : '0;

endmodule

// File: tb/ea_sort_term_ctrl_tb.sv
module ea_sort_term_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int POP    = 8;
  localparam int RW     = 16;
  localparam int FW     = 4;
  localparam int ELT    = 2;
  localparam int NOFF   = 4;
  localparam int NUPD   = 2;
  localparam int NGEN   = 3;
  localparam int AW     = 3;
  localparam int NRUN   = 2;

  localparam logic [RW-1:0] INIT_TAB [NRUN][POP] = '{
    '{16'h7001, 16'h3002, 16'h9003, 16'h3004, 16'h1005, 16'hC006, 16'h7007, 16'h2008},
    '{16'h5011, 16'h5012, 16'h2013, 16'h5014, 16'h2015, 16'h5016, 16'h5017, 16'h2018}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_done = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_we;
  logic [RW-1:0] mem_wdata;
  logic [RW-1:0] mem_rdata;
  logic upd_req;
  logic [NUPD*AW-1:0] upd_addr = '0;
  logic xo_go;
  logic off_valid = 1'b0;
  logic [RW-1:0] off_data = '0;
  logic res_valid;
  logic [RW-1:0] res_path;

  logic [RW-1:0] mem [POP];
  logic [RW-1:0] exp_pop [POP];
  int n_chk = 0;
  int n_bad = 0;
  int xo_seen = 0;
  int we_seen = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_sort_term_ctrl #(
    .POP_SIZE(POP), .REC_W(RW), .FIT_W(FW), .ELITE(ELT),
    .N_OFFS(NOFF), .N_UPD(NUPD), .MAX_GEN(NGEN)
  ) dut_i (
    .clk(clk), .rst(rst), .init_done(init_done), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .upd_req(upd_req), .upd_addr(upd_addr), .xo_go(xo_go),
    .off_valid(off_valid), .off_data(off_data), .res_valid(res_valid),
    .res_path(res_path)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (!rst && xo_go) xo_seen <= xo_seen + 1;
    if (!rst && mem_we) we_seen <= we_seen + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // stable insertion sort on the fitness key
  task automatic sort_exp();
    for (int i = 1; i < POP; i++) begin
      logic [RW-1:0] v;
      int j;
      v = exp_pop[i];
      j = i - 1;
      while (j >= 0 && exp_pop[j][RW-1 -: FW] > v[RW-1 -: FW]) begin
        exp_pop[j+1] = exp_pop[j];
        j--;
      end
      exp_pop[j+1] = v;
    end
  endtask

  task automatic compare_pop(input string tag);
    for (int i = 0; i < POP; i++) check(tag, 32'(mem[i]), 32'(exp_pop[i]));
  endtask

  task automatic wait_xo(input string tag);
    int t;
    t = 0;
    while (!xo_go && t < 2000) begin @(negedge clk); t++; end
    if (!xo_go) check(tag, 32'd0, 32'd1);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(negedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mem_we in reset", 32'(mem_we), 0);
    check("R1 upd_req in reset", 32'(upd_req), 0);
    check("R1 xo_go in reset", 32'(xo_go), 0);
    check("R1 res_valid in reset", 32'(res_valid), 0);
    rst = 1'b0;

    for (int run = 0; run < NRUN; run++) begin
      int xo0;
      int we0;
      for (int i = 0; i < POP; i++) begin
        mem[i] = INIT_TAB[run][i];
        exp_pop[i] = INIT_TAB[run][i];
      end
      xo0 = xo_seen;
      we0 = we_seen;
      // stray offspring while waiting for the initial population
      off_valid = 1'b1;
      off_data  = 16'hFFFF;
      repeat (2) @(negedge clk);
      off_valid = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 no write before init", 32'(we_seen - we0), 0);
      check("R2 no request before init", 32'(xo_seen - xo0), 0);
      init_done = 1'b1;
      @(negedge clk);
      init_done = 1'b0;
      sort_exp();

      for (int g = 0; g < NGEN; g++) begin
        int a0;
        int a1;
        int base;
        int slot;
        logic [RW-1:0] elite0;
        logic [RW-1:0] elite1;
        wait_xo("R7 request arrives");
        compare_pop(run == 1 ? "R3 stable sort with ties" : "R3 sorted population");
        if (g == 0)
          for (int i = 0; i < POP; i++) check("R9 stray offspring absent", 32'(mem[i] == 16'hFFFF), 0);
        check("R4 upd_req with xo_go", 32'(upd_req), 1);
        elite0 = mem[0];
        elite1 = mem[1];
        a0 = (g * 3 + run + 1) % 8;
        a1 = (g * 5 + 2 * run) % 8;
        upd_addr = {AW'(a1), AW'(a0)};
        @(negedge clk);
        check("R4 request lasts one cycle", 32'(xo_go), 0);
        base = a0 + a1;
        while (base >= POP - ELT) base -= POP - ELT;
        slot = ELT + base;
        for (int k = 0; k < NOFF; k++) begin
          logic [RW-1:0] od;
          od = {FW'((run * 7 + g * 5 + k * 3 + 1) % 16), 4'(run), 4'(g), 4'(k)};
          off_valid = 1'b1;
          off_data  = od;
          exp_pop[slot] = od;
          slot++;
          if (slot == POP) slot = ELT;
          @(negedge clk);
        end
        off_valid = 1'b0;
        repeat (NOFF) @(negedge clk);
        check("R6 elite slot 0 kept", 32'(mem[0]), 32'(elite0));
        check("R6 elite slot 1 kept", 32'(mem[1]), 32'(elite1));
        compare_pop("R5 offspring placement");
        sort_exp();
      end

      begin
        int t;
        t = 0;
        while (!res_valid && t < 2000) begin @(negedge clk); t++; end
      end
      check("R8 result strobe", 32'(res_valid), 1);
      check("R8 best path", 32'(res_path), 32'(exp_pop[0]));
      check("R8 request count", 32'(xo_seen - xo0), NGEN);
      compare_pop("R7 final sort");
      @(negedge clk);
      check("R8 strobe one cycle", 32'(res_valid), 0);
      check("R8 path cleared", 32'(res_path), 0);
      xo0 = xo_seen;
      we0 = we_seen;
      repeat (6) @(negedge clk);
      check("R10 idle after result no request", 32'(xo_seen - xo0), 0);
      check("R10 idle after result no write", 32'(we_seen - we0), 0);
    end
    summary();
  end

endmodule